// File: doc/BRIEF.md
# Banked GPIO Interrupt Router

This block gathers the per-pin interrupt flags of three GPIO banks and presents them on a fixed set of 41 lines toward an interrupt controller. Bank 0 contributes 14 pins, bank 1 contributes 24 pins and bank 2 contributes 32 pins. Only 38 direct lines exist. The first 32 of them can each be handed over to the bank-2 pin with the same index through one bit of a 32-bit route-select register.

A flag that currently has no direct line is not lost. It is folded into one of three per-bank aggregate lines, and the interrupt handler then polls that bank to find the source. The route-select register is written and read through a small full-word register port. The lines themselves are a purely combinational function of the flags and the stored select value.

Top module: `gpio_irq_router`

## Requirements
- R1: The output vector has exactly 41 lines. Lines 0 to 37 are direct lines. Lines 38, 39 and 40 are the aggregate lines for bank 0, bank 1 and bank 2 respectively.
- R2: While select bit n is 0, line n (n from 0 to 13) carries bank-0 flag n.
- R3: While select bit 14+q is 0, line 14+q carries bank-1 flag q. Lines 32 to 37 carry bank-1 flags 18 to 23 at all times, whatever the select value.
- R4: While select bit n is 1 (n from 0 to 31), line n carries bank-2 flag n in place of the bank-0 or bank-1 flag.
- R5: Line 38 is the OR of every bank-0 flag n whose select bit n is 1.
- R6: Line 39 is the OR of every bank-1 flag q (q from 0 to 17) whose select bit 14+q is 1. Bank-1 flags 18 to 23 never reach line 39.
- R7: Line 40 is the OR of every bank-2 flag n whose select bit n is 0. With an all-zero select value, every bank-2 flag reaches line 40 only.
- R8: The select register is cleared by reset. A write loads the full 32-bit word on the rising clock edge at which the write enable is high. The read port always shows the stored value.
- R9: A flag change appears on its line in the same cycle. A select write changes the routing only from the cycle after the write edge.
- R10: Every flag that is set drives at least one line high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the select register |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_wr_en | input | 1 | Loads sel_wr_data into the select register |
| sel_wr_data | input | 32 | New route-select word |
| sel_rd_data | output | 32 | Stored route-select word |
| flags_b0 | input | 14 | Bank-0 interrupt flags |
| flags_b1 | input | 24 | Bank-1 interrupt flags |
| flags_b2 | input | 32 | Bank-2 interrupt flags |
| irq_lines | output | 41 | Interrupt-controller lines |

## Verification
Every line depends combinationally on the flags, so a flag change is due on the lines within the same cycle. The bench drives the flags after a falling edge and compares all 41 lines with its model a few nanoseconds later, before the next rising edge. A select write becomes visible only after the rising edge that stores it. For that reason the bench first checks the lines and the read port against the old select value while the write is still pending. It then checks them against the new value after the edge. Random flag and select patterns are mixed with directed all-ones, all-zeros and single-bit patterns, and with a reset in the middle of the run.

// File: rtl/gpio_irq_router_pkg.sv
// Shared constants and helpers for the banked GPIO interrupt router.
// Assumes bank-2 has no more pins than there are direct lines.
package gpio_irq_router_pkg;

    // Default geometry of the three banks.
    localparam int unsigned DEF_B0_PINS = 14;
    localparam int unsigned DEF_B1_PINS = 24;
    localparam int unsigned DEF_B2_PINS = 32;

    // Number of aggregate (per-bank OR) lines appended after the direct lines.
    localparam int unsigned AGG_LINES = 3;

    // Owner of a direct line when its select bit is clear.
    typedef enum logic [1:0] {
        SRC_BANK0 = 2'd0,
        SRC_BANK1 = 2'd1,
        SRC_BANK2 = 2'd2
    } src_bank_e;

    // Native (select-clear) owner of a direct line.
    function automatic src_bank_e native_bank(input int unsigned line, input int unsigned b0_pins);
        return (line < b0_pins) ? SRC_BANK0 : SRC_BANK1;
    endfunction

    // True when a direct line has a select bit that can hand it to bank 2.
    function automatic bit line_shared(input int unsigned line, input int unsigned b2_pins);
        return line < b2_pins;
    endfunction

endpackage

// File: rtl/gir_sel_reg.sv
// Route-select register with a full-word write port and a read port.
// Assumes a synchronous active-low reset; writes take effect on the clock edge.
module gir_sel_reg #(
    parameter int unsigned SEL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_data,
    output logic [SEL_W-1:0] sel_q
);

    // Holds the select word; cleared by reset, loaded on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_en) begin
            sel_q <= wr_data;
        end
    end

    AST_SEL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (sel_q == '0)); // R8
    AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |-> (sel_q == $past(wr_data))); // R8
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |-> $stable(sel_q)); // R8

endmodule

// File: rtl/gir_route_mask.sv
// Derives, per bank, which pins currently own a direct line.
// Assumes B2_PINS does not exceed B0_PINS + B1_PINS.
module gir_route_mask #(
    parameter int unsigned B0_PINS = 14,
    parameter int unsigned B1_PINS = 24,
    parameter int unsigned B2_PINS = 32
) (
    input  logic [B2_PINS-1:0] sel,
    output logic [B0_PINS-1:0] has_line_b0,
    output logic [B1_PINS-1:0] has_line_b1,
    output logic [B2_PINS-1:0] has_line_b2
);

    // Bank 0: a pin keeps its line unless its shared line is given to bank 2.
    for (genvar p = 0; p < B0_PINS; p++) begin : g_b0
        if (p < B2_PINS) begin : g_shared
            assign has_line_b0[p] = ~sel[p];
        end else begin : g_fixed
            assign has_line_b0[p] = 1'b1;
        end
    end

    // Bank 1: lines past the select width are never handed over.
    for (genvar q = 0; q < B1_PINS; q++) begin : g_b1
        localparam int unsigned LINE = B0_PINS + q;
        if (LINE < B2_PINS) begin : g_shared
            assign has_line_b1[q] = ~sel[LINE];
        end else begin : g_fixed
            assign has_line_b1[q] = 1'b1;
        end
    end

    // Bank 2: a pin owns its line only while its select bit is set.
    for (genvar n = 0; n < B2_PINS; n++) begin : g_b2
        assign has_line_b2[n] = sel[n];
    end

endmodule

// File: rtl/gir_direct_mux.sv
// Builds the direct lines: native bank-0/bank-1 flag or the shared bank-2 flag.
// Assumes B2_PINS does not exceed the number of direct lines.
module gir_direct_mux
    import gpio_irq_router_pkg::*;
#(
    parameter int unsigned B0_PINS = 14,
    parameter int unsigned B1_PINS = 24,
    parameter int unsigned B2_PINS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [B2_PINS-1:0]         sel,
    input  logic [B0_PINS-1:0]         flags_b0,
    input  logic [B1_PINS-1:0]         flags_b1,
    input  logic [B2_PINS-1:0]         flags_b2,
    output logic [B0_PINS+B1_PINS-1:0] direct
);

    localparam int unsigned DIR_LINES = B0_PINS + B1_PINS;

    // One selector per direct line; structure depends on the line's owners.
    for (genvar i = 0; i < DIR_LINES; i++) begin : g_line
        localparam src_bank_e NATIVE = native_bank(i, B0_PINS);
        logic native_flag;

        if (NATIVE == SRC_BANK0) begin : g_nat0
            assign native_flag = flags_b0[i];
        end else begin : g_nat1
            assign native_flag = flags_b1[i-B0_PINS];
        end

        if (line_shared(i, B2_PINS)) begin : g_shared
            // Shared line: select bit picks the bank-2 flag.
            always_comb begin
                direct[i] = sel[i] ? flags_b2[i] : native_flag;
            end
        end else begin : g_fixed
            assign direct[i] = native_flag;
        end
    end

    AST_TOP_LINES_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        direct[DIR_LINES-1:B2_PINS] == flags_b1[B1_PINS-1:B2_PINS-B0_PINS]); // R3

endmodule

// File: rtl/gir_aggregate.sv
// Per-bank OR of the flags that currently have no direct line.
// Assumes the masks mark pins that own a direct line with a 1.
module gir_aggregate #(
    parameter int unsigned B0_PINS = 14,
    parameter int unsigned B1_PINS = 24,
    parameter int unsigned B2_PINS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [B2_PINS-1:0] sel,
    input  logic [B0_PINS-1:0] flags_b0,
    input  logic [B1_PINS-1:0] flags_b1,
    input  logic [B2_PINS-1:0] flags_b2,
    input  logic [B0_PINS-1:0] has_line_b0,
    input  logic [B1_PINS-1:0] has_line_b1,
    input  logic [B2_PINS-1:0] has_line_b2,
    output logic [2:0]         agg
);

    // Reduces the unrouted flags of each bank to one line.
    always_comb begin
        agg[0] = |(flags_b0 & ~has_line_b0);
        agg[1] = |(flags_b1 & ~has_line_b1);
        agg[2] = |(flags_b2 & ~has_line_b2);
    end

    AST_B2_DEFAULT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> (agg[2] == (|flags_b2))); // R7
    AST_B0_NONE_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[B0_PINS-1:0] == '0) |-> !agg[0]); // R5
    AST_B1_UPPER_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_b1[B2_PINS-B0_PINS-1:0] == '0) |-> !agg[1]); // R6

endmodule

// File: rtl/gpio_irq_router.sv
// Top of the banked GPIO interrupt router: select register, direct-line
// selectors and per-bank aggregate lines. Assumes flags are synchronous
// to clk or already stable; the line outputs are combinational.
module gpio_irq_router
    import gpio_irq_router_pkg::*;
#(
    parameter int unsigned B0_PINS = DEF_B0_PINS,
    parameter int unsigned B1_PINS = DEF_B1_PINS,
    parameter int unsigned B2_PINS = DEF_B2_PINS
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 sel_wr_en,
    input  logic [B2_PINS-1:0]                   sel_wr_data,
    output logic [B2_PINS-1:0]                   sel_rd_data,
    input  logic [B0_PINS-1:0]                   flags_b0,
    input  logic [B1_PINS-1:0]                   flags_b1,
    input  logic [B2_PINS-1:0]                   flags_b2,
    output logic [B0_PINS+B1_PINS+AGG_LINES-1:0] irq_lines
);

    localparam int unsigned DIR_LINES = B0_PINS + B1_PINS;

    logic [B2_PINS-1:0]   sel_q;
    logic [B0_PINS-1:0]   has_line_b0;
    logic [B1_PINS-1:0]   has_line_b1;
    logic [B2_PINS-1:0]   has_line_b2;
    logic [DIR_LINES-1:0] direct;
    logic [2:0]           agg;

    gir_sel_reg #(.SEL_W(B2_PINS)) i_sel_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sel_wr_en),
        .wr_data (sel_wr_data),
        .sel_q   (sel_q)
    );

    gir_route_mask #(.B0_PINS(B0_PINS), .B1_PINS(B1_PINS), .B2_PINS(B2_PINS)) i_mask (
        .sel         (sel_q),
        .has_line_b0 (has_line_b0),
        .has_line_b1 (has_line_b1),
        .has_line_b2 (has_line_b2)
    );

    gir_direct_mux #(.B0_PINS(B0_PINS), .B1_PINS(B1_PINS), .B2_PINS(B2_PINS)) i_direct (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel_q),
        .flags_b0 (flags_b0),
        .flags_b1 (flags_b1),
        .flags_b2 (flags_b2),
        .direct   (direct)
    );

    gir_aggregate #(.B0_PINS(B0_PINS), .B1_PINS(B1_PINS), .B2_PINS(B2_PINS)) i_agg (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel_q),
        .flags_b0    (flags_b0),
        .flags_b1    (flags_b1),
        .flags_b2    (flags_b2),
        .has_line_b0 (has_line_b0),
        .has_line_b1 (has_line_b1),
        .has_line_b2 (has_line_b2),
        .agg         (agg)
    );

    // Direct lines first, then the bank-0, bank-1, bank-2 aggregates.
    always_comb begin
        irq_lines   = {agg, direct};
        sel_rd_data = sel_q;
    end

    AST_B0_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (|flags_b0) |-> (|irq_lines[B0_PINS-1:0] || irq_lines[DIR_LINES])); // R10
    AST_B1_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (|flags_b1) |-> (|irq_lines[DIR_LINES-1:B0_PINS] || irq_lines[DIR_LINES+1])); // R10
    AST_B2_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (|flags_b2) |-> (|(irq_lines[B2_PINS-1:0] & sel_rd_data) || irq_lines[DIR_LINES+2])); // R10
    AST_QUIET_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_b0 == '0) && (flags_b1 == '0) && (flags_b2 == '0)) |-> (irq_lines == '0)); // R1

endmodule

// File: tb/test_gpio_irq_router.sv
// Self-checking bench: behavioural model of all 41 lines compared each cycle.
module test_gpio_irq_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr_en = 1'b0;
    logic [31:0] sel_wr_data = '0;
    logic [31:0] sel_rd_data;
    logic [13:0] flags_b0 = '0;
    logic [23:0] flags_b1 = '0;
    logic [31:0] flags_b2 = '0;
    logic [40:0] irq_lines;

    int total = 0;
    int bad = 0;
    logic [31:0] model_sel = '0;

    always #10 clk = ~clk;

    gpio_irq_router i_gpio_irq_router (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_wr_en   (sel_wr_en),
        .sel_wr_data (sel_wr_data),
        .sel_rd_data (sel_rd_data),
        .flags_b0    (flags_b0),
        .flags_b1    (flags_b1),
        .flags_b2    (flags_b2),
        .irq_lines   (irq_lines)
    );

    // Behavioural expectation of one line from the requirement text.
    function automatic logic expect_line(input int ln, input logic [31:0] s);
        logic r;
        r = 1'b0;
        if (ln < 38) begin
            if (ln < 32 && s[ln]) r = flags_b2[ln];            // R4
            else if (ln < 14)     r = flags_b0[ln];            // R2
            else                  r = flags_b1[ln-14];         // R3
        end else if (ln == 38) begin
            for (int p = 0; p < 14; p++) if (s[p] && flags_b0[p]) r = 1'b1;           // R5
        end else if (ln == 39) begin
            for (int q = 0; q < 18; q++) if (s[14+q] && flags_b1[q]) r = 1'b1;        // R6
        end else begin
            for (int n = 0; n < 32; n++) if (!s[n] && flags_b2[n]) r = 1'b1;          // R7
        end
        return r;
    endfunction

    function automatic string line_tag(input int ln, input logic [31:0] s);
        if (ln < 32 && s[ln]) return "R4";
        if (ln < 14) return "R2";
        if (ln < 38) return "R3";
        if (ln == 38) return "R5";
        if (ln == 39) return "R6";
        return "R7";
    endfunction

    task automatic check_lines(input logic [31:0] s, input string ctx);
        for (int ln = 0; ln < 41; ln++) begin
            logic e;
            e = expect_line(ln, s);
            total++;
            if (irq_lines[ln] !== e) begin
                bad++;
                $display("FAIL %s %s line %0d: actual=%b expected=%b", line_tag(ln, s), ctx, ln, irq_lines[ln], e);
            end
        end
        // R10: any set flag must show on some line.
        total++;
        if (((|flags_b0) || (|flags_b1) || (|flags_b2)) && (irq_lines == '0)) begin
            bad++;
            $display("FAIL R10 %s: actual=%h expected nonzero", ctx, irq_lines);
        end
    endtask

    task automatic check_rd(input logic [31:0] e, input string tag);
        total++;
        if (sel_rd_data !== e) begin
            bad++;
            $display("FAIL %s select read: actual=%h expected=%h", tag, sel_rd_data, e);
        end
    endtask

    task automatic set_flags(input logic [13:0] a, input logic [23:0] b, input logic [31:0] c);
        @(negedge clk);
        flags_b0 = a; flags_b1 = b; flags_b2 = c;
        #2;
        check_lines(model_sel, "R9 same-cycle");
    endtask

    task automatic write_sel(input logic [31:0] v);
        @(negedge clk);
        sel_wr_en = 1'b1; sel_wr_data = v;
        #2;
        check_lines(model_sel, "R9 before edge");
        check_rd(model_sel, "R9");
        @(posedge clk);
        #1 model_sel = v;
        @(negedge clk);
        sel_wr_en = 1'b0;
        #2;
        check_rd(model_sel, "R8");
        check_lines(model_sel, "after write");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_rd(32'h0, "R8 reset");
        check_lines(32'h0, "reset");
        total++;
        if ($bits(irq_lines) != 41) begin
            bad++;
            $display("FAIL R1 width: actual=%0d expected=41", $bits(irq_lines));
        end
        @(negedge clk) rst_n = 1'b1;

        // Default routing: bank 2 only on the aggregate (R7).
        set_flags('0, '0, 32'h0000_0001);
        set_flags('0, '0, 32'h8000_0000);
        set_flags(14'h3fff, 24'hff_ffff, 32'hffff_ffff);
        set_flags(14'h2000, 24'h80_0001, '0);

        // All lines handed to bank 2: upper bank-1 lines unaffected (R3).
        write_sel(32'hffff_ffff);
        set_flags(14'h3fff, 24'hfc_0000, '0);
        set_flags('0, 24'h03_ffff, 32'h0000_0000);
        set_flags('0, '0, 32'ha5a5_5a5a);

        // Single select bits at the bank boundaries.
        write_sel(32'h0000_2000);
        set_flags(14'h2000, '0, 32'h0000_2000);
        write_sel(32'h0000_4000);
        set_flags('0, 24'h00_0001, 32'h0000_4000);
        write_sel(32'h8000_0000);
        set_flags('0, 24'h02_0000, 32'h8000_0000);

        // Random sweep of flags and select values.
        for (int k = 0; k < 400; k++) begin
            if (k % 8 == 0) write_sel($urandom);
            set_flags(14'($urandom), 24'($urandom), $urandom);
        end

        // Reset mid-run clears the select register (R8).
        write_sel(32'h1234_5678);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1 model_sel = '0;
        @(negedge clk) rst_n = 1'b1;
        #2;
        check_rd(32'h0, "R8 mid reset");
        set_flags(14'h0001, 24'h00_0001, 32'h0000_0001);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule